// File: doc/BRIEF.md
# Serial Symbol-and-Control Word Receiver

This block sits between a line-code signal processor and the transmit and receive analog sections of a single-pair digital subscriber line front end. The processor sends one 16-bit control word per symbol period over a single serial wire. The wire is sampled by a free-running oversampling clock at 48 times the symbol rate. A separate baud-rate clock, also driven by the processor, marks where each symbol period begins.

The block brings the baud clock into the oversampling domain and uses its falling edge to align a slot counter. It shifts in the word during the first 16 slots and discards the serial input for the rest of the period. On the cycle after the last data slot, it updates a signed 2B1Q symbol level together with a one-cycle strobe, and it refreshes the receive gain code, the loopback flag and the power mode. Reserved gain codes and the spare power code cannot reach the analog side. A reserved gain code is also recorded in a sticky flag.

Top module: `symword_rx`

## Requirements
- R1: A falling edge of `baud_clk_i` passes through a two-stage synchroniser. The serial bit sampled on the third rising `clk` edge that sees `baud_clk_i` low is slot 1. Slots 1..16 carry word bits 15 down to 0, MSB first, and slots 17..48 are ignored.
- R2: `sym_valid_o` is high for exactly one cycle per frame, in the cycle right after the slot-16 edge. `sym_level_o`, `rx_gain_o`, `loopback_o` and `pwr_mode_o` change only in a cycle where `sym_valid_o` is high.
- R3: When word bit 15 (transmit enable) is 0, `sym_level_o` is 0 (3'b000), whatever bits 14:13 hold.
- R4: When bit 15 is 1, bits 14:13 give the level as two's complement: 00 gives -3 (3'b101), 01 gives -1 (3'b111), 11 gives +1 (3'b001) and 10 gives +3 (3'b011).
- R5: Word bits 12:10 with values 0..4 are copied to `rx_gain_o` and mean 0, 3, 6, 9 and 12 dB. `rx_gain_o` never exceeds 4.
- R6: A gain code of 5, 6 or 7 leaves `rx_gain_o` unchanged and sets `gain_err_o`. `gain_err_o` then stays high until reset.
- R7: Word bit 9 is copied to `loopback_o`: 1 means the line input is disconnected and 0 means normal operation.
- R8: Word bits 7:6 set `pwr_mode_o`: 01 is low, 10 is medium and 11 is normal. Code 00 keeps the previous mode, so `pwr_mode_o` is never 00.
- R9: Word bit 8 and bits 5:0 have no effect on any output.
- R10: With `rst` high and after reset, `sym_level_o` is 0, `sym_valid_o` is 0, `rx_gain_o` is 0, `loopback_o` is 0, `pwr_mode_o` is 11 and `gain_err_o` is 0. No strobe occurs before the first baud falling edge.
- R11: A baud falling edge that arrives before slot 48 restarts the frame at slot 1. The next word is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 48 per symbol |
| rst | input | 1 | Synchronous active-high reset |
| baud_clk_i | input | 1 | Baud-rate clock; falling edge starts a frame |
| sdata_i | input | 1 | Serial control word, MSB first |
| sym_level_o | output | 3 | Signed symbol level (-3, -1, 0, +1, +3) |
| sym_valid_o | output | 1 | One-cycle strobe for a new symbol |
| rx_gain_o | output | 3 | Receive gain code, 3 dB per step |
| loopback_o | output | 1 | Line input disconnect flag |
| pwr_mode_o | output | 2 | Power mode (01 low, 10 medium, 11 normal) |
| gain_err_o | output | 1 | Sticky reserved-gain flag |

## Verification
The bound checker watches every cycle for the following:
- a valid strobe that lasts more than one cycle;
- an output that changes outside a strobe cycle;
- a symbol level outside the five legal values;
- a gain code above 4;
- a power mode of 00;
- an error flag that drops.

Some behaviour can only be shown by the bench's frame scenarios:
- the exact slot position of each word bit after the synchroniser delay;
- the mapping of each field to its output;
- the retention of previous settings on reserved codes;
- the realignment after a shortened frame.

The sweep covers every combination of bits 15:6 and randomises the reserved bits and the ignored slots.

// File: rtl/symrx_pkg.sv
package symrx_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    PWR_SPARE = 2'b00,
    PWR_LOW   = 2'b01,
    PWR_MED   = 2'b10,
    PWR_NORM  = 2'b11
  } pwr_mode_e;

  // Field layout of the serial control word, MSB first on the wire.
  typedef struct packed {
    logic       tx_en;
    logic [1:0] sym;
    logic [2:0] gain;
    logic       lpbk;
    logic       unused;
    logic [1:0] pwr;
    logic [5:0] rsvd;
  } ctl_word_t;

  localparam logic [2:0] GAIN_MAX = 3'd4;

  function automatic logic [2:0] sym_to_level(input logic en, input logic [1:0] code);
    logic [2:0] lv;
    if (!en) lv = 3'b000;
    else begin
      case (code)
        2'b00:   lv = 3'b101;
        2'b01:   lv = 3'b111;
        2'b11:   lv = 3'b001;
        default: lv = 3'b011;
      endcase
    end
    return lv;
  endfunction

endpackage

// File: rtl/symrx_baud_sync.sv
module symrx_baud_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic baud_i,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= baud_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/symrx_slot_ctr.sv
module symrx_slot_ctr #(
  parameter int SLOTS      = 48,
  parameter int DATA_SLOTS = 16,
  localparam int CNT_W     = $clog2(SLOTS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start_i,
  output logic shift_en_o,
  output logic word_last_o
);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_SLOTS);
  localparam logic [CNT_W-1:0] FIRST     = CNT_W'(1);

  // 0 means not yet aligned; 1..SLOTS is the slot of the last sample.
  logic [CNT_W-1:0] slot_q, slot_nxt;

  always_comb begin
    if (frame_start_i)          slot_nxt = FIRST;
    else if (slot_q == '0)      slot_nxt = '0;
    else if (slot_q == LAST_SLOT) slot_nxt = FIRST;
    else                        slot_nxt = slot_q + FIRST;
  end

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else     slot_q <= slot_nxt;
  end

  assign shift_en_o  = (slot_nxt != '0) && (slot_nxt <= LAST_DATA);
  assign word_last_o = (slot_nxt == LAST_DATA);
endmodule

// File: rtl/symrx_shift.sv
module symrx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)       sh_q <= '0;
    else if (en_i) sh_q <= {sh_q[W-2:0], din_i};
  end

  // Word including the bit being captured at this edge.
  assign word_o = {sh_q[W-2:0], din_i};
endmodule

// File: rtl/symrx_decode.sv
module symrx_decode
  import symrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [2:0]       level_o,
  output logic             valid_o,
  output logic [2:0]       gain_o,
  output logic             lpbk_o,
  output logic [1:0]       pwr_o,
  output logic             err_o
);
  ctl_word_t  w;
  logic [2:0] lv_nxt;
  logic       gain_ok;
  logic       pwr_ok;

  always_comb begin
    w       = ctl_word_t'(word_i);
    lv_nxt  = sym_to_level(w.tx_en, w.sym);
    gain_ok = (w.gain <= GAIN_MAX);
    pwr_ok  = (w.pwr != PWR_SPARE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o <= 3'b000;
      valid_o <= 1'b0;
      gain_o  <= 3'd0;
      lpbk_o  <= 1'b0;
      pwr_o   <= PWR_NORM;
      err_o   <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        level_o <= lv_nxt;
        lpbk_o  <= w.lpbk;
        if (gain_ok) gain_o <= w.gain;
        else         err_o  <= 1'b1;
        if (pwr_ok)  pwr_o  <= w.pwr;
      end
    end
  end
endmodule

// File: rtl/symword_rx.sv
module symword_rx #(
  parameter int SLOTS_PER_BAUD = 48,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_clk_i,
  input  logic       sdata_i,
  output logic [2:0] sym_level_o,
  output logic       sym_valid_o,
  output logic [2:0] rx_gain_o,
  output logic       loopback_o,
  output logic [1:0] pwr_mode_o,
  output logic       gain_err_o
);
  import symrx_pkg::*;

  logic              frame_start;
  logic              shift_en;
  logic              word_last;
  logic [WORD_W-1:0] word_now;

  symrx_baud_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .baud_i(baud_clk_i), .fall_o(frame_start)
  );

  symrx_slot_ctr #(.SLOTS(SLOTS_PER_BAUD), .DATA_SLOTS(WORD_W)) u_ctr (
    .clk(clk), .rst(rst), .frame_start_i(frame_start),
    .shift_en_o(shift_en), .word_last_o(word_last)
  );

  symrx_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .en_i(shift_en), .din_i(sdata_i), .word_o(word_now)
  );

  symrx_decode u_dec (
    .clk(clk), .rst(rst), .load_i(word_last), .word_i(word_now),
    .level_o(sym_level_o), .valid_o(sym_valid_o), .gain_o(rx_gain_o),
    .lpbk_o(loopback_o), .pwr_o(pwr_mode_o), .err_o(gain_err_o)
  );
endmodule

// File: rtl/symword_rx_chk.sv
module symword_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] sym_level_o,
  input logic       sym_valid_o,
  input logic [2:0] rx_gain_o,
  input logic       loopback_o,
  input logic [1:0] pwr_mode_o,
  input logic       gain_err_o
);
  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    sym_valid_o |=> !sym_valid_o);
  // R2
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sym_valid_o |-> $stable(sym_level_o) && $stable(rx_gain_o)
                     && $stable(loopback_o) && $stable(pwr_mode_o));
  // R4
  level_legal_chk: assert property (@(posedge clk) disable iff (rst)
    sym_level_o == 3'b000 || sym_level_o == 3'b001 || sym_level_o == 3'b011
    || sym_level_o == 3'b111 || sym_level_o == 3'b101);
  // R5
  gain_range_chk: assert property (@(posedge clk) disable iff (rst)
    rx_gain_o <= 3'd4);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    gain_err_o |=> gain_err_o);
  // R8
  pwr_never_spare_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_mode_o != 2'b00);
endmodule

bind symword_rx symword_rx_chk u_chk (
  .clk(clk), .rst(rst), .sym_level_o(sym_level_o), .sym_valid_o(sym_valid_o),
  .rx_gain_o(rx_gain_o), .loopback_o(loopback_o), .pwr_mode_o(pwr_mode_o),
  .gain_err_o(gain_err_o)
);

// File: tb/symword_rx_bench.sv
`timescale 1ns/1ps
module symword_rx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_clk_i = 1'b1;
  logic       sdata_i = 1'b0;
  logic [2:0] sym_level_o;
  logic       sym_valid_o;
  logic [2:0] rx_gain_o;
  logic       loopback_o;
  logic [1:0] pwr_mode_o;
  logic       gain_err_o;

  int checks = 0;
  int errors = 0;

  logic [2:0] m_level = 3'b000;
  logic [2:0] m_gain  = 3'd0;
  logic       m_lpbk  = 1'b0;
  logic [1:0] m_pwr   = 2'b11;
  logic       m_err   = 1'b0;

  always #2.5 clk = ~clk;

  symword_rx u_symword_rx (
    .clk(clk), .rst(rst), .baud_clk_i(baud_clk_i), .sdata_i(sdata_i),
    .sym_level_o(sym_level_o), .sym_valid_o(sym_valid_o), .rx_gain_o(rx_gain_o),
    .loopback_o(loopback_o), .pwr_mode_o(pwr_mode_o), .gain_err_o(gain_err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_level(input logic [15:0] w);
    if (!w[15]) return 3'b000;
    case (w[14:13])
      2'b00:   return 3'b101;
      2'b01:   return 3'b111;
      2'b11:   return 3'b001;
      default: return 3'b011;
    endcase
  endfunction

  // One frame of len cycles: baud low for the first half (max 24), data in
  // loop indices 2..17 (slot 1..16), junk elsewhere. Strobe expected at index 18.
  task automatic run_frame(input logic [15:0] w, input int len, input string req);
    int nval = 0;
    int vidx = -1;
    int moved = 0;
    logic [2:0] s_lv = sym_level_o, s_g = rx_gain_o;
    logic       s_lb = loopback_o;
    logic [1:0] s_p = pwr_mode_o;
    logic [2:0] g_lv = 3'b000, g_g = 3'd0;
    logic       g_lb = 1'b0, g_e = 1'b0;
    logic [1:0] g_p = 2'b00;
    int lowlen = (len / 2 < 24) ? len / 2 : 24;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (sym_valid_o) begin
        nval++; vidx = i;
        g_lv = sym_level_o; g_g = rx_gain_o; g_lb = loopback_o;
        g_p = pwr_mode_o; g_e = gain_err_o;
      end else if (sym_level_o != s_lv || rx_gain_o != s_g ||
                   loopback_o != s_lb || pwr_mode_o != s_p) begin
        moved++;
      end
      s_lv = sym_level_o; s_g = rx_gain_o; s_lb = loopback_o; s_p = pwr_mode_o;
      baud_clk_i = (i < lowlen) ? 1'b0 : 1'b1;
      sdata_i = (i >= 2 && i <= 17) ? w[17-i] : 1'($urandom);
    end
    m_level = exp_level(w);
    m_lpbk  = w[9];
    if (w[12:10] <= 3'd4) m_gain = w[12:10]; else m_err = 1'b1;
    if (w[7:6] != 2'b00) m_pwr = w[7:6];
    chk(nval == 1, "R2", "strobes per frame", nval, 1);
    chk(vidx == 18, "R1", "strobe slot position", vidx, 18);
    chk(moved == 0, "R2", "output change without strobe", moved, 0);
    chk(g_lv == m_level, w[15] ? "R4" : "R3", "symbol level (R9 junk)", g_lv, m_level);
    chk(g_g == m_gain, (w[12:10] > 3'd4) ? "R6" : "R5", "gain code", g_g, m_gain);
    chk(g_e == m_err, "R6", "gain error flag", g_e, m_err);
    chk(g_lb == m_lpbk, "R7", "loopback", g_lb, m_lpbk);
    chk(g_p == m_pwr, "R8", "power mode", g_p, m_pwr);
    if (req != "") chk(nval == 1 && g_lv == m_level, req, "frame decoded", g_lv, m_level);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nv;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(sym_valid_o == 1'b0 && sym_level_o == 3'b000, "R10", "reset strobe/level",
        {sym_valid_o, sym_level_o}, 0);
    chk(rx_gain_o == 3'd0 && loopback_o == 1'b0 && gain_err_o == 1'b0, "R10",
        "reset gain/loopback/err", {rx_gain_o, loopback_o, gain_err_o}, 0);
    chk(pwr_mode_o == 2'b11, "R10", "reset power", pwr_mode_o, 3);
    @(negedge clk); rst = 1'b0;
    // Baud held high: serial junk must produce nothing (R10).
    nv = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      sdata_i = 1'($urandom);
      if (sym_valid_o) nv++;
    end
    chk(nv == 0, "R10", "strobe before first baud edge", nv, 0);
    chk(pwr_mode_o == 2'b11 && rx_gain_o == 3'd0, "R10", "defaults held",
        {pwr_mode_o, rx_gain_o}, 24);
    // Sweep all combinations of bits 15:6, bits 5:0 random (R9).
    for (int hi = 0; hi < 1024; hi++) begin
      run_frame({10'(hi), 6'($urandom)}, 48, "");
    end
    // Reserved bits and bit 8 flipped: same outputs (R9).
    run_frame(16'hB2C0, 48, "R9");
    run_frame(16'hB2C0 ^ 16'h013F, 48, "R9");
    chk(gain_err_o == 1'b1, "R6", "sticky flag after sweep", gain_err_o, 1);
    // Short frames then normal frames: realignment (R11).
    run_frame(16'hE440, 30, "");
    run_frame(16'h9880, 48, "R11");
    run_frame(16'hC0C0, 37, "");
    run_frame(16'h2A40, 48, "R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule